// File: doc/BRIEF.md
# Pipelined Dense-Layer Neuron

This block computes one neuron of a quantised fully connected layer. Each of its `N_IN` signed inputs is multiplied by a weight held locally. The products are then summed through a binary adder tree, with a register after every tree level. For the hidden-layer form, a rectifier stage follows the tree. The block is fully pipelined. It accepts a new input vector on every clock, and the result for each vector comes out a fixed number of cycles later, together with a matching valid flag.

Weights are written beforehand, one at a time, through a small index/data port. There is no bias term. The sum is kept at full precision: each adder level adds one bit of width, so no sum can wrap. A layer is built by instantiating many copies side by side. A typical hidden layer has 32 neurons of 11 inputs with the rectifier. A typical output layer has 16 neurons of 16 inputs with no rectifier.

Top module: `dense_neuron`

## Requirements
- R1: A synchronous active-high reset clears all weights to zero and clears every pipeline stage. In the cycle after reset, `out_valid` is 0 and `out_sum` is 0.
- R2: When `wt_we` is high at a clock edge, weight index `wt_addr` takes `wt_data`. A vector accepted at that same edge still uses the old weight. Vectors accepted at later edges use the new weight.
- R3: A weight write whose index is `N_IN` or above changes nothing.
- R4: `out_sum` equals the signed sum over i of input i times weight i. No bias is added, and the width is 2*`DATA_W` plus the tree depth, so the sum never overflows. For 8-bit data, the magnitude never exceeds `N_IN`*16384.
- R5: Latency is 1 multiply stage, plus one stage per adder level (the depth is the base-2 logarithm of `N_IN`, rounded up), plus 1 when the rectifier is enabled. With `N_IN`=11 and `USE_RELU`=1 it is 6 cycles. With `N_IN`=16 and `USE_RELU`=0 it is 5 cycles.
- R6: Vectors may arrive on consecutive cycles. Each result depends only on its own vector and the weights in force when that vector was accepted.
- R7: `out_valid` repeats `in_valid` delayed by exactly the latency of R5, with gaps kept.
- R8: With `USE_RELU`=1, a negative sum gives 0, and a zero or positive sum is output unchanged.
- R9: With `USE_RELU`=0, negative sums reach `out_sum` unchanged.
- R10: Input element i occupies `in_vec[i*DATA_W +: DATA_W]` and is paired with weight index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | clog2(N_IN) | Weight index to write |
| wt_data | input | DATA_W | Signed weight value |
| in_valid | input | 1 | Input vector present this cycle |
| in_vec | input | N_IN*DATA_W | Packed signed input elements |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 2*DATA_W+depth | Signed neuron result |

## Verification
Suppose an adder level paired the wrong operands, or dropped an odd leftover. The sum would then be wrong on the first valid result whose inputs reach that path, exactly the latency after the vector went in. If a passthrough register were missing, one operand would come from the neighbouring vector. That shows up only in back-to-back traffic with changing inputs, so streams without gaps are compared sum by sum. A stale weight register, or a write landing at the wrong index, shows up in the first vector that uses that index. A valid pipeline of the wrong length moves `out_valid` away from the data by a whole cycle, and this is checked on every edge.

// File: rtl/dense_pkg.sv
package dense_pkg;

    // Number of registered adder levels needed to reduce n operands to one.
    function automatic int tree_depth(input int n);
        int c;
        int d;
        c = n;
        d = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            d = d + 1;
        end
        return d;
    endfunction

    // Operand count present after lvl adder levels.
    function automatic int nodes_at(input int n, input int lvl);
        int c;
        c = n;
        for (int i = 0; i < lvl; i++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

    function automatic int sum_width(input int n, input int dw);
        return 2 * dw + tree_depth(n);
    endfunction

    function automatic int pipe_latency(input int n, input bit relu);
        return 1 + tree_depth(n) + (relu ? 1 : 0);
    endfunction

    function automatic int addr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dn_weight_bank.sv
module dn_weight_bank #(
    parameter int N_IN   = 11,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_idx,
    input  logic signed [DATA_W-1:0] wr_val,
    output logic signed [DATA_W-1:0] coef [N_IN]
);

    // One register per input; an index with no matching slot falls through.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_IN; i++) begin
                coef[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (wr_en && (wr_idx == ADDR_W'(i))) begin
                    coef[i] <= wr_val;
                end
            end
        end
    end

endmodule

// File: rtl/dn_mult_stage.sv
module dn_mult_stage #(
    parameter int N_IN   = 11,
    parameter int DATA_W = 8,
    localparam int PW    = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] x    [N_IN],
    input  logic signed [DATA_W-1:0] coef [N_IN],
    output logic signed [PW-1:0]     prod [N_IN]
);

    // All products of one vector formed in the same cycle, then registered.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_IN; i++) begin
                prod[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                prod[i] <= x[i] * coef[i];
            end
        end
    end

endmodule

// File: rtl/dn_adder_tree.sv
module dn_adder_tree
    import dense_pkg::*;
#(
    parameter int N_IN  = 11,
    parameter int PW    = 16,
    localparam int LV   = tree_depth(N_IN),
    localparam int SW   = PW + LV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [PW-1:0] leaf [N_IN],
    output logic signed [SW-1:0] root
);

    if (LV == 0) begin : g_flat
        assign root = leaf[0];
    end else begin : g_tree
        for (genvar l = 1; l <= LV; l++) begin : g_lvl
            localparam int IC  = nodes_at(N_IN, l - 1);
            localparam int OC  = nodes_at(N_IN, l);
            localparam int IW  = PW + l - 1;
            localparam int LW  = PW + l;

            logic signed [IW-1:0] src [IC];

            if (l == 1) begin : g_from_leaf
                for (genvar i = 0; i < IC; i++) begin : g_cp
                    assign src[i] = leaf[i];
                end
            end else begin : g_from_lvl
                for (genvar i = 0; i < IC; i++) begin : g_cp
                    assign src[i] = g_lvl[l-1].g_node[i].q;
                end
            end

            for (genvar j = 0; j < OC; j++) begin : g_node
                logic signed [LW-1:0] q;
                if (2 * j + 1 < IC) begin : g_add
                    always_ff @(posedge clk) begin
                        if (rst) q <= '0;
                        else     q <= {src[2*j][IW-1], src[2*j]}
                                    + {src[2*j+1][IW-1], src[2*j+1]};
                    end
                end else begin : g_carry
                    // Unpaired operand is delayed one level to keep alignment.
                    always_ff @(posedge clk) begin
                        if (rst) q <= '0;
                        else     q <= {src[2*j][IW-1], src[2*j]};
                    end
                end
            end
        end

        assign root = g_lvl[LV].g_node[0].q;
    end

endmodule

// File: rtl/dn_relu_stage.sv
module dn_relu_stage #(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (d[W-1]) q <= '0;
        else             q <= d;
    end

endmodule

// File: rtl/dense_neuron.sv
module dense_neuron
    import dense_pkg::*;
#(
    parameter int N_IN     = 11,
    parameter int DATA_W   = 8,
    parameter bit USE_RELU = 1'b1
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          wt_we,
    input  logic [addr_width(N_IN)-1:0]                   wt_addr,
    input  logic signed [DATA_W-1:0]                      wt_data,
    input  logic                                          in_valid,
    input  logic [N_IN*DATA_W-1:0]                        in_vec,
    output logic                                          out_valid,
    output logic signed [sum_width(N_IN, DATA_W)-1:0]     out_sum
);

    localparam int AW  = addr_width(N_IN);
    localparam int PW  = 2 * DATA_W;
    localparam int SW  = sum_width(N_IN, DATA_W);
    localparam int LAT = pipe_latency(N_IN, USE_RELU);

    logic signed [DATA_W-1:0] elem [N_IN];
    logic signed [DATA_W-1:0] coef [N_IN];
    logic signed [PW-1:0]     prod [N_IN];
    logic signed [SW-1:0]     tree_sum;
    logic [LAT-1:0]           vld_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_unpack
        assign elem[i] = in_vec[i*DATA_W +: DATA_W];
    end

    dn_weight_bank #(
        .N_IN   (N_IN),
        .DATA_W (DATA_W),
        .ADDR_W (AW)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wt_we),
        .wr_idx (wt_addr),
        .wr_val (wt_data),
        .coef   (coef)
    );

    dn_mult_stage #(
        .N_IN   (N_IN),
        .DATA_W (DATA_W)
    ) u_mult (
        .clk  (clk),
        .rst  (rst),
        .x    (elem),
        .coef (coef),
        .prod (prod)
    );

    dn_adder_tree #(
        .N_IN (N_IN),
        .PW   (PW)
    ) u_tree (
        .clk  (clk),
        .rst  (rst),
        .leaf (prod),
        .root (tree_sum)
    );

    if (USE_RELU) begin : g_act
        dn_relu_stage #(
            .W (SW)
        ) u_relu (
            .clk (clk),
            .rst (rst),
            .d   (tree_sum),
            .q   (out_sum)
        );
    end else begin : g_lin
        assign out_sum = tree_sum;
    end

    // Valid travels beside the data through one flop per stage.
    if (LAT > 1) begin : g_vld_long
        always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end else begin : g_vld_short
        always_ff @(posedge clk) begin
            if (rst) vld_q <= '0;
            else     vld_q <= in_valid;
        end
    end

    assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/dense_neuron_chk.sv
module dense_neuron_chk
    import dense_pkg::*;
#(
    parameter int N_IN     = 11,
    parameter int DATA_W   = 8,
    parameter bit USE_RELU = 1'b1,
    localparam int SW      = sum_width(N_IN, DATA_W),
    localparam int LAT     = pipe_latency(N_IN, USE_RELU)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [SW-1:0] out_sum
);

    localparam longint MAXMAG = longint'(N_IN) * (longint'(1) << (2 * DATA_W - 2));

    logic [LAT:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else     seen <= {seen[LAT-1:0], in_valid};
    end

    // R7
    valid_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == seen[LAT-1]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sum == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'(out_sum) <= MAXMAG && longint'(out_sum) >= -MAXMAG));

    if (USE_RELU) begin : g_relu_chk
        // R8
        relu_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> !out_sum[SW-1]);
    end

endmodule

bind dense_neuron dense_neuron_chk #(
    .N_IN     (N_IN),
    .DATA_W   (DATA_W),
    .USE_RELU (USE_RELU)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/dense_neuron_test.sv
module dense_neuron_test;

    localparam int NA   = 11;
    localparam int NB   = 16;
    localparam int LATA = 6;   // 1 mult + 4 levels + ReLU
    localparam int LATB = 5;   // 1 mult + 4 levels

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              a_we = 0, b_we = 0;
    logic [3:0]        a_addr = 0, b_addr = 0;
    logic signed [7:0] a_wd = 0, b_wd = 0;
    logic              a_vld = 0, b_vld = 0;
    logic signed [7:0] a_x [16];
    logic signed [7:0] b_x [16];
    logic [NA*8-1:0]   a_flat;
    logic [NB*8-1:0]   b_flat;
    logic              a_ov, b_ov;
    logic signed [19:0] a_os, b_os;

    always_comb begin
        for (int i = 0; i < NA; i++) a_flat[i*8 +: 8] = a_x[i];
        for (int i = 0; i < NB; i++) b_flat[i*8 +: 8] = b_x[i];
    end

    dense_neuron #(.N_IN(NA), .DATA_W(8), .USE_RELU(1'b1)) uut (
        .clk(clk), .rst(rst), .wt_we(a_we), .wt_addr(a_addr), .wt_data(a_wd),
        .in_valid(a_vld), .in_vec(a_flat), .out_valid(a_ov), .out_sum(a_os));

    dense_neuron #(.N_IN(NB), .DATA_W(8), .USE_RELU(1'b0)) uut_lin (
        .clk(clk), .rst(rst), .wt_we(b_we), .wt_addr(b_addr), .wt_data(b_wd),
        .in_valid(b_vld), .in_vec(b_flat), .out_valid(b_ov), .out_sum(b_os));

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: weights, and a queue of expected results per instance.
    logic signed [7:0] wa [16];
    logic signed [7:0] wb [16];
    bit     qa_v [$];  longint qa_s [$];  bit qa_n [$];
    bit     qb_v [$];  longint qb_s [$];  bit qb_n [$];
    bit started = 0;

    function automatic longint dot(input int n, input logic signed [7:0] v [16],
                                   input logic signed [7:0] w [16]);
        longint s = 0;
        for (int i = 0; i < n; i++) s += longint'(v[i]) * longint'(w[i]);
        return s;
    endfunction

    task automatic model_reset();
        qa_v.delete(); qa_s.delete(); qa_n.delete();
        qb_v.delete(); qb_s.delete(); qb_n.delete();
        for (int i = 0; i < LATA; i++) begin qa_v.push_back(0); qa_s.push_back(0); qa_n.push_back(0); end
        for (int i = 0; i < LATB; i++) begin qb_v.push_back(0); qb_s.push_back(0); qb_n.push_back(0); end
        for (int i = 0; i < 16; i++) begin wa[i] = 0; wb[i] = 0; end
    endtask

    always @(posedge clk) begin
        longint sa, sb;
        started = 1;
        if (rst) begin
            model_reset();
        end else begin
            sa = dot(NA, a_x, wa);
            sb = dot(NB, b_x, wb);
            void'(qa_v.pop_front()); void'(qa_s.pop_front()); void'(qa_n.pop_front());
            void'(qb_v.pop_front()); void'(qb_s.pop_front()); void'(qb_n.pop_front());
            qa_v.push_back(a_vld); qa_s.push_back(sa < 0 ? 0 : sa); qa_n.push_back(sa < 0);
            qb_v.push_back(b_vld); qb_s.push_back(sb); qb_n.push_back(sb < 0);
            if (a_we && a_addr < NA) wa[a_addr] = a_wd;
            if (b_we) wb[b_addr] = b_wd;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check(a_ov == qa_v[0], "R7", {tag, " valid hidden"}, a_ov, qa_v[0]);
            check(longint'(a_os) == qa_s[0], qa_n[0] ? "R8" : "R4",
                  {tag, " sum hidden"}, a_os, qa_s[0]);
            check(b_ov == qb_v[0], "R7", {tag, " valid output"}, b_ov, qb_v[0]);
            check(longint'(b_os) == qb_s[0], qb_n[0] ? "R9" : "R4",
                  {tag, " sum output"}, b_os, qb_s[0]);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle_inputs();
        a_we = 0; b_we = 0; a_vld = 0; b_vld = 0;
    endtask

    task automatic load(input int idx, input logic signed [7:0] va, input logic signed [7:0] vb);
        a_we = 1; a_addr = 4'(idx); a_wd = va;
        b_we = 1; b_addr = 4'(idx); b_wd = vb;
        step();
        a_we = 0; b_we = 0;
    endtask

    task automatic rand_vec();
        for (int i = 0; i < 16; i++) begin
            a_x[i] = 8'($urandom);
            b_x[i] = 8'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual %0d cycles expected fewer", 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin a_x[i] = 0; b_x[i] = 0; end
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        // R1: cleared outputs after reset
        check(a_os == 0 && !a_ov, "R1", "hidden after reset", a_os, 0);
        check(b_os == 0 && !b_ov, "R1", "output after reset", b_os, 0);

        // R2 / R3: load weights; indexes 11..15 on the hidden neuron must be ignored
        tag = "R3";
        for (int i = 0; i < 16; i++) load(i, 8'(i * 23 - 120), 8'(101 - i * 13));

        // R10: one-hot inputs reveal the element/weight pairing
        tag = "R10";
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < 16; i++) begin a_x[i] = 0; b_x[i] = 0; end
            a_x[k] = 8'(k + 1); b_x[k] = 8'(-(k + 1));
            a_vld = 1; b_vld = 1;
            step();
        end
        idle_inputs();
        repeat (8) step();

        // R5: latency counted from the accepting edge
        tag = "R5";
        rand_vec();
        a_vld = 1; b_vld = 1;
        @(posedge clk); #2;
        a_vld = 0; b_vld = 0;
        begin
            int ka = 0, kb = 0;
            for (int c = 1; c <= 12; c++) begin
                @(negedge clk);
                if (a_ov && ka == 0) ka = c;
                if (b_ov && kb == 0) kb = c;
            end
            check(ka == LATA, "R5", "hidden latency", ka, LATA);
            check(kb == LATB, "R5", "output latency", kb, LATB);
        end
        step();

        // R4 / R8 / R9: extremes for full-precision width and sign handling
        tag = "R4";
        for (int i = 0; i < 16; i++) load(i, -8'sd128, -8'sd128);
        for (int i = 0; i < 16; i++) begin a_x[i] = -8'sd128; b_x[i] = -8'sd128; end
        a_vld = 1; b_vld = 1; step();
        for (int i = 0; i < 16; i++) begin a_x[i] = 8'sd127; b_x[i] = 8'sd127; end
        tag = "R8";
        step();
        for (int i = 0; i < 16; i++) begin a_x[i] = 0; b_x[i] = 0; end
        step();
        idle_inputs();
        repeat (8) step();
        @(negedge clk);

        // R6 / R2: back-to-back random traffic with gaps and weight writes mid-stream
        tag = "R6";
        for (int n = 0; n < 400; n++) begin
            rand_vec();
            a_vld = ($urandom % 4) != 0;
            b_vld = ($urandom % 4) != 0;
            a_we = ($urandom % 8) == 0; a_addr = 4'($urandom); a_wd = 8'($urandom);
            b_we = ($urandom % 8) == 0; b_addr = 4'($urandom); b_wd = 8'($urandom);
            step();
        end
        idle_inputs();

        // R1: reset in the middle of a stream flushes everything
        tag = "R1";
        for (int n = 0; n < 4; n++) begin rand_vec(); a_vld = 1; b_vld = 1; step(); end
        rst = 1; step(); rst = 0;
        @(negedge clk);
        check(!a_ov && a_os == 0, "R1", "hidden after mid reset", a_os, 0);
        check(!b_ov && b_os == 0, "R1", "output after mid reset", b_os, 0);
        for (int n = 0; n < 20; n++) begin rand_vec(); step(); end
        idle_inputs();
        repeat (10) step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule